// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product. There is no sign extension of the operands and no separate negation step. All N×N partial-product bits are formed in parallel in one stage. The terms that involve exactly one sign bit are formed in complemented (NAND) form. Two constant ones, at columns N and 2N−1, correct the weight of those complemented terms, so a single array of unsigned adders gives the signed result.

A second stage reduces the partial-product rows and the correction row. It uses a chain of carry-save rows of full adders. A ripple adder then resolves the final sum and carry vectors.

The caller presents both operands together with `in_valid`. When the output register is enabled (the default), the product and `out_valid` appear one clock later. On cycles without `in_valid`, the product register keeps its last value.

Top module: `smul_top`

## Requirements
- R1: With `in_valid` high, the output after the register equals the two's-complement product of `mcand` and `mplier`, as a 2N-bit two's-complement value, for every operand pair.
- R2: The most negative operand times itself gives +2^(2N−2), a positive value with no overflow. For N=5, −16 × −16 = +256. For N=8, −128 × −128 = +16384.
- R3: With `OUT_REG`=1, `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R4: The product output changes only after a cycle with `in_valid` high. After a cycle with `in_valid` low, it holds its previous value whatever the operands were.
- R5: While `rst_n` is low, `out_valid` and `product` are 0.
- R6: For N=5, operands 5'b10011 (−13) and 5'b10001 (−15) give +195.
- R7: A multiplier of all ones (−1) gives the two's-complement negation of the multiplicand, reduced to 2N bits.
- R8: A zero operand on either side gives a product of 0.
- R9: The two top product bits differ only for the most-negative-squared case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| out_valid | output | 1 | Product register holds a fresh result |
| product | output | 2*WIDTH | Signed product, two's complement |

## Verification
With the output register enabled, each product and its `out_valid` are due one rising edge after the operands are presented.

The bench changes inputs on the falling edge and samples on the next falling edge. By that point exactly one register stage has captured the result.

Operands are streamed back to back, so every cycle both checks the previous pair and presents a new one. A cycle with `in_valid` low is followed by a sample one falling edge later, which confirms that the held product and a low `out_valid` are unchanged.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // One partial-product bit; inverted when exactly one index is a sign bit.
  function automatic logic pp_term(input logic a_bit, input logic b_bit,
                                   input logic flip);
    logic t;
    t = a_bit & b_bit;
    return flip ? ~t : t;
  endfunction

  // True when a (row, column) pair touches exactly one sign position.
  function automatic logic is_mixed_sign(input int row, input int col,
                                         input int w);
    return (row == w - 1) != (col == w - 1);
  endfunction

  // Full-adder sum and carry kept as functions for reuse by checkers.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/smul_fa.sv
module smul_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = smul_pkg::fa_sum(x, y, z);
  assign co = smul_pkg::fa_carry(x, y, z);
endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]                  mcand,
  input  logic [WIDTH-1:0]                  mplier,
  output logic [WIDTH-1:0][2*WIDTH-1:0]     pp_rows,
  output logic [2*WIDTH-1:0]                corr_row
);
  localparam int PW = 2 * WIDTH;

  always_comb begin
    pp_rows = '0;
    for (int r = 0; r < WIDTH; r++) begin
      for (int c = 0; c < WIDTH; c++) begin
        pp_rows[r][r+c] = smul_pkg::pp_term(mcand[c], mplier[r],
                            smul_pkg::is_mixed_sign(r, c, WIDTH));
      end
    end
  end

  always_comb begin
    corr_row           = '0;
    corr_row[WIDTH]    = 1'b1;
    corr_row[PW-1]     = 1'b1;
  end
endmodule

// File: rtl/smul_array.sv
module smul_array #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0][2*WIDTH-1:0] pp_rows,
  input  logic [2*WIDTH-1:0]            corr_row,
  output logic [2*WIDTH-1:0]            sum_vec,
  output logic [2*WIDTH-1:0]            carry_vec,
  output logic [2*WIDTH-1:0]            result
);
  localparam int PW     = 2 * WIDTH;
  localparam int STAGES = WIDTH - 1;

  logic [WIDTH-1:0][PW-1:0] acc_s;
  logic [WIDTH-1:0][PW-1:0] acc_c;

  assign acc_s[0] = pp_rows[0];
  assign acc_c[0] = pp_rows[1];

  // Carry-save rows: each stage folds in one further addend.
  for (genvar k = 0; k < STAGES; k++) begin : g_csa
    logic [PW-1:0] addend;
    logic [PW-1:0] s_bits;
    logic [PW-2:0] c_bits;
    if (k + 2 < WIDTH) begin : g_pp
      assign addend = pp_rows[k+2];
    end else begin : g_corr
      assign addend = corr_row;
    end
    for (genvar b = 0; b < PW - 1; b++) begin : g_bit
      smul_fa u_fa (
        .x (acc_s[k][b]),
        .y (acc_c[k][b]),
        .z (addend[b]),
        .s (s_bits[b]),
        .co(c_bits[b])
      );
    end
    assign s_bits[PW-1] = acc_s[k][PW-1] ^ acc_c[k][PW-1] ^ addend[PW-1];
    assign acc_s[k+1]   = s_bits;
    assign acc_c[k+1]   = {c_bits, 1'b0};
  end

  assign sum_vec   = acc_s[WIDTH-1];
  assign carry_vec = acc_c[WIDTH-1];

  // Final ripple stage; carry out of the top column is discarded.
  logic [PW-1:0] rc;
  assign rc[0] = 1'b0;
  for (genvar b = 0; b < PW - 1; b++) begin : g_rip
    smul_fa u_fa (
      .x (sum_vec[b]),
      .y (carry_vec[b]),
      .z (rc[b]),
      .s (result[b]),
      .co(rc[b+1])
    );
  end
  assign result[PW-1] = sum_vec[PW-1] ^ carry_vec[PW-1] ^ rc[PW-1];
endmodule

// File: rtl/smul_top.sv
module smul_top #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WIDTH-1:0]     mcand,
  input  logic [WIDTH-1:0]     mplier,
  output logic                 out_valid,
  output logic [2*WIDTH-1:0]   product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0][PW-1:0] pp_rows;
  logic [PW-1:0]            corr_row;
  logic [PW-1:0]            sum_vec;
  logic [PW-1:0]            carry_vec;
  logic [PW-1:0]            comb_product;

  smul_ppgen #(.WIDTH(WIDTH)) u_ppgen (
    .mcand   (mcand),
    .mplier  (mplier),
    .pp_rows (pp_rows),
    .corr_row(corr_row)
  );

  smul_array #(.WIDTH(WIDTH)) u_array (
    .pp_rows  (pp_rows),
    .corr_row (corr_row),
    .sum_vec  (sum_vec),
    .carry_vec(carry_vec),
    .result   (comb_product)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        product   <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) product <= comb_product;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign product   = comb_product;
  end
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic               out_valid,
  input logic [2*WIDTH-1:0] product,
  input logic [2*WIDTH-1:0] comb_product
);
  localparam int PW = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [PW-1:0]    MAX_POS  = {2'b01, {(PW-2){1'b0}}};

  logic signed [PW-1:0] ext_a, ext_b, ref_full;
  assign ext_a    = {{WIDTH{mcand[WIDTH-1]}}, mcand};
  assign ext_b    = {{WIDTH{mplier[WIDTH-1]}}, mplier};
  assign ref_full = ext_a * ext_b;

  // R1
  array_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> comb_product == ref_full);

  // R2
  most_neg_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mcand == MOST_NEG && mplier == MOST_NEG) |-> comb_product == MAX_POS);

  if (OUT_REG) begin : g_reg_chk
    // R1
    reg_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) |-> product == $past(ref_full));

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

    // R4
    hold_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(product));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && product == '0));

    // R9
    top_bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && product[PW-1] != product[PW-2]) |-> product == MAX_POS);
  end else begin : g_comb_chk
    // R3
    valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end
endmodule

bind smul_top smul_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_smul_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .mcand       (mcand),
  .mplier      (mplier),
  .out_valid   (out_valid),
  .product     (product),
  .comb_product(comb_product)
);

// File: tb/test_smul_top.sv
module test_smul_top;
  localparam int WB = 8;
  localparam int WS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            vb = 1'b0, vs = 1'b0;
  logic [WB-1:0]   ab = '0, bb = '0;
  logic [WS-1:0]   as_ = '0, bs = '0;
  logic            ovb, ovs;
  logic [2*WB-1:0] pb;
  logic [2*WS-1:0] ps;

  smul_top #(.WIDTH(WB), .OUT_REG(1'b1)) i_smul_top (
    .clk(clk), .rst_n(rst_n), .in_valid(vb), .mcand(ab), .mplier(bb),
    .out_valid(ovb), .product(pb));

  smul_top #(.WIDTH(WS), .OUT_REG(1'b1)) i_smul_top_w5 (
    .clk(clk), .rst_n(rst_n), .in_valid(vs), .mcand(as_), .mplier(bs),
    .out_valid(ovs), .product(ps));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sval(input longint bits, input int w);
    return bits[w-1] ? bits - (64'sd1 <<< w) : bits;
  endfunction

  function automatic longint expect_prod(input longint a, input longint b, input int w);
    longint p;
    p = sval(a, w) * sval(b, w);
    return p & ((64'sd1 <<< (2 * w)) - 1);
  endfunction

  // Present a pair to the 5-bit unit and check it one cycle later.
  task automatic run5(input int a, input int b, input string req);
    as_ = WS'(a); bs = WS'(b); vs = 1'b1;
    @(negedge clk);
    check({req, " valid"}, longint'(ovs), 1);
    check(req, longint'(ps), expect_prod(a, b, WS));
  endtask

  task automatic run8(input int a, input int b, input string req);
    ab = WB'(a); bb = WB'(b); vb = 1'b1;
    @(negedge clk);
    check({req, " valid"}, longint'(ovb), 1);
    check(req, longint'(pb), expect_prod(a, b, WB));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint held;
    repeat (3) @(negedge clk);
    // R5: outputs cleared during reset
    check("R5 valid8", longint'(ovb), 0);
    check("R5 prod8", longint'(pb), 0);
    check("R5 valid5", longint'(ovs), 0);
    check("R5 prod5", longint'(ps), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: worked example
    run5(5'b10011, 5'b10001, "R6");
    check("R6 value", longint'(ps), 195);

    // R1 and R9: exhaustive sweep of the 5-bit unit
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        run5(a, b, "R1");
        check("R9", longint'(ps[2*WS-1] != ps[2*WS-2]), longint'(a == 16 && b == 16));
      end
    end

    // R2: most negative squared, both sizes
    run5(16, 16, "R2");
    check("R2 value5", longint'(ps), 256);
    vs = 1'b0;
    run8(128, 128, "R2");
    check("R2 value8", longint'(pb), 16384);

    // R7: multiplier of -1 negates the multiplicand
    for (int a = 0; a < 256; a++) begin
      run8(a, 255, "R7");
      check("R7 neg", longint'(pb), (-sval(a, WB)) & 16'hFFFF);
    end

    // R8: zero on either side
    for (int k = 0; k < 256; k += 17) begin
      run8(k, 0, "R8");
      check("R8 a", longint'(pb), 0);
      run8(0, k, "R8");
      check("R8 b", longint'(pb), 0);
    end

    // R1: random pairs for the 8-bit unit
    for (int n = 0; n < 3000; n++) begin
      run8(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), "R1 rand");
    end

    // R3 and R4: idle cycle keeps product, valid drops
    run8(8'h9C, 8'h37, "R4 setup");
    held = longint'(pb);
    vb = 1'b0; ab = 8'h7F; bb = 8'h7F;
    @(negedge clk);
    check("R3 idle valid", longint'(ovb), 0);
    check("R4 hold", longint'(pb), held);
    @(negedge clk);
    check("R4 hold again", longint'(pb), held);
    run8(8'h7F, 8'h7F, "R3 resume");
    vb = 1'b0;
    @(negedge clk);
    check("R3 one cycle", longint'(ovb), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule